// File: doc/BRIEF.md
# Link Self-Test Transmit Sequencer

The block sits in front of an 8b/10b encoder on the transmit side of a serial link. It drives the encoder's character and control-flag inputs, and it drives an active-low read strobe toward an upstream FIFO. It runs on the bit-rate clock and divides it into byte periods of `PHASES` (10) clocks. All inputs are sampled once per byte, at the clock edge that ends phase 9. The outputs then hold for the whole of the next byte.

With self-test off, user characters, the control flag and both data enables pass through unchanged. The read strobe is low for the first six phases of each byte whenever the sampled enable A is active. With self-test on and both enables idle, the block sends a fixed data character whose encoded form is an alternating one-zero bit stream. With self-test on and either enable active, it sends a repeating 511-byte loop. Each loop opens with a start marker, and the remaining bytes are drawn from a free-running 9-bit LFSR. The read strobe drops for the whole of the last loop byte and stays high on every other loop byte.

A separate bypass selection forwards a raw 10-bit word past the encoder.

Top module: `lst_tx_seq`

## Requirements
- R1: Inputs are sampled only at the clock edge where the internal phase counter goes from 9 to 0. The first such edge is the 10th rising edge after reset is released. `chr_o`, `ctl_o`, `ena_no`, `enb_no`, `byp_o` and `raw_o` change only at that edge, so an input change in mid-byte shows up only at the next byte boundary.
- R2: While `rst_ni` is low, the outputs hold these values: `chr_o`=0, `ctl_o`=0, `ena_no`=1, `enb_no`=1, `byp_o`=0, `raw_o`=0 and `rd_no`=1. The LFSR is set to all ones.
- R3: When `bist_en_ni`=1 is sampled (user mode), the next byte carries `chr_o`=`data_i`, `ctl_o`=`ctrl_i`, `ena_no`=`ena_ni` and `enb_no`=`enb_ni`.
- R4: In user mode, `rd_no` is low during phases 0 to 5 of a byte whose sampled `ena_ni` was 0. It is high during phases 6 to 9 of that byte, and high for the whole of any byte whose sampled `ena_ni` was 1.
- R5: When `bist_en_ni`=0, `ena_ni`=1 and `enb_ni`=1 are sampled (idle pattern), the block sends `chr_o`=8'h4A (D10.2) with `ctl_o`=0, `ena_no`=0, `enb_no`=1, and holds `rd_no`=1.
- R6: When `bist_en_ni`=0 and at least one of `ena_ni` or `enb_ni` is 0 are sampled (loop mode), `ena_no`=0 and `enb_no`=1. The byte sent depends on the current LFSR state `s`:
  - if `s`=9'h1FF, `chr_o`=8'hBC with `ctl_o`=1 (start marker);
  - otherwise, if `s[8:6]`=0, `chr_o`=8'h3C with `ctl_o`=1;
  - otherwise, `chr_o`=`s[7:0]` with `ctl_o`=0.
- R7: The LFSR advances once per byte in every mode. Its next state is {`s[7:0]`, `s[8]`^`s[4]`}. The loop is therefore 511 bytes long from one start marker to the next.
- R8: In loop mode, `rd_no` stays low for all ten phases of the byte whose state is 9'h0FF, which is the last byte of the loop. It is high on every other loop byte. The byte that follows the last byte is the start marker.
- R9: If `svs_i`=1 is sampled while `bist_en_ni`=0, the current byte uses state 9'h1FF (the start marker) and the sequence continues from there. While `bist_en_ni`=1, `svs_i` affects neither the outputs nor the sequence.
- R10: `byp_o` follows the sampled `bypass_i`. `raw_o` carries the sampled `raw_i` when `bypass_i`=1 and is 0 otherwise. The character path is unaffected by `bypass_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bist_en_ni | input | 1 | Self-test enable, active low |
| ena_ni | input | 1 | Data enable A, active low |
| enb_ni | input | 1 | Data enable B, active low |
| svs_i | input | 1 | Send-violation request; restarts the loop while self-test is on |
| bypass_i | input | 1 | Selects the raw 10-bit bypass path |
| data_i | input | 8 | User character |
| ctrl_i | input | 1 | User control-character flag |
| raw_i | input | 10 | Raw 10-bit word for bypass |
| chr_o | output | 8 | Character to encoder |
| ctl_o | output | 1 | Control flag to encoder |
| ena_no | output | 1 | Data enable A to encoder, active low |
| enb_no | output | 1 | Data enable B to encoder, active low |
| byp_o | output | 1 | Encoder bypass select |
| raw_o | output | 10 | Raw word to serializer |
| rd_no | output | 1 | FIFO read strobe, active low |

## Verification
A corrupted LFSR state appears as a wrong character on the very next loop byte. It also moves the read-strobe drop away from the 511th byte, so a single loop sweep exposes it. A phase counter that slips or overruns shifts every character change and every strobe edge off the ten-clock grid, and this is visible within one byte. A mode decode that is wrong shows up at the next byte boundary in one of two ways: the enables to the encoder take wrong values, or the strobe takes the wrong shape.

// File: rtl/lst_pkg.sv
package lst_pkg;
  typedef enum logic [1:0] {
    MODE_USER = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_LOOP = 2'd2
  } mode_e;

  localparam logic [7:0] IDLE_CHR  = 8'h4A;  // D10.2
  localparam logic [7:0] MARK_CHR  = 8'hBC;  // K28.5 loop start
  localparam logic [7:0] KFILL_CHR = 8'h3C;  // K28.1 control filler
endpackage

// File: rtl/lst_phase.sv
module lst_phase #(
  parameter int PHASES = 10,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [PW-1:0] phase_o,
  output logic          wrap_o
);
  logic [PW-1:0] ph_q;

  assign wrap_o  = (ph_q == PW'(PHASES - 1));
  assign phase_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ph_q <= '0;
    else if (wrap_o) ph_q <= '0;
    else             ph_q <= ph_q + PW'(1);
  end
endmodule

// File: rtl/lst_pattern.sv
module lst_pattern #(
  parameter int         W     = 9,
  parameter int         TAP   = 5,
  parameter int         DW    = 8,
  parameter int         KBITS = 3,
  parameter logic [7:0] MARK  = 8'hBC,
  parameter logic [7:0] KFILL = 8'h3C
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          restart_i,
  output logic [DW-1:0] chr_o,
  output logic          ctl_o,
  output logic          last_o
);
  localparam logic [W-1:0] SEED = '1;
  localparam logic [W-1:0] LAST = {1'b0, {(W-1){1'b1}}};  // predecessor of SEED

  logic [W-1:0] lfsr_q, cur, nxt;

  assign cur = restart_i ? SEED : lfsr_q;
  assign nxt = {cur[W-2:0], cur[W-1] ^ cur[TAP-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lfsr_q <= SEED;
    else if (adv_i) lfsr_q <= nxt;
  end

  always_comb begin
    if (cur == SEED) begin
      chr_o = MARK[DW-1:0];
      ctl_o = 1'b1;
    end else if (cur[W-1 -: KBITS] == '0) begin
      chr_o = KFILL[DW-1:0];
      ctl_o = 1'b1;
    end else begin
      chr_o = cur[DW-1:0];
      ctl_o = 1'b0;
    end
  end

  assign last_o = (cur == LAST);
endmodule

// File: rtl/lst_strobe.sv
module lst_strobe
  import lst_pkg::*;
#(
  parameter int PHASES     = 10,
  parameter int LOW_PHASES = 6,
  localparam int PW = $clog2(PHASES)
) (
  input  logic [PW-1:0] phase_i,
  input  mode_e         mode_i,
  input  logic          ena_ni,
  input  logic          last_i,
  output logic          rd_no
);
  logic user_low, loop_low;

  assign user_low = (mode_i == MODE_USER) && !ena_ni && (phase_i < PW'(LOW_PHASES));
  assign loop_low = (mode_i == MODE_LOOP) && last_i;
  assign rd_no    = !(user_low || loop_low);
endmodule

// File: rtl/lst_tx_seq.sv
module lst_tx_seq
  import lst_pkg::*;
#(
  parameter int DW         = 8,
  parameter int RW         = 10,
  parameter int PHASES     = 10,
  parameter int LOW_PHASES = 6,
  parameter int LFSR_W     = 9,
  parameter int LFSR_TAP   = 5,
  parameter int KBITS      = 3,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bist_en_ni,
  input  logic          ena_ni,
  input  logic          enb_ni,
  input  logic          svs_i,
  input  logic          bypass_i,
  input  logic [DW-1:0] data_i,
  input  logic          ctrl_i,
  input  logic [RW-1:0] raw_i,
  output logic [DW-1:0] chr_o,
  output logic          ctl_o,
  output logic          ena_no,
  output logic          enb_no,
  output logic          byp_o,
  output logic [RW-1:0] raw_o,
  output logic          rd_no
);
  logic [PW-1:0] phase_q;
  logic          wrap;
  mode_e         mode_d, mode_q;
  logic [DW-1:0] pat_chr;
  logic          pat_ctl, pat_last, last_q;

  lst_phase #(.PHASES(PHASES)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .phase_o(phase_q),
    .wrap_o (wrap)
  );

  lst_pattern #(
    .W(LFSR_W), .TAP(LFSR_TAP), .DW(DW), .KBITS(KBITS),
    .MARK(MARK_CHR), .KFILL(KFILL_CHR)
  ) u_pattern (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (wrap),
    .restart_i(!bist_en_ni && svs_i),
    .chr_o    (pat_chr),
    .ctl_o    (pat_ctl),
    .last_o   (pat_last)
  );

  always_comb begin
    if (bist_en_ni)          mode_d = MODE_USER;
    else if (ena_ni && enb_ni) mode_d = MODE_IDLE;
    else                     mode_d = MODE_LOOP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_USER;
      chr_o  <= '0;
      ctl_o  <= 1'b0;
      ena_no <= 1'b1;
      enb_no <= 1'b1;
      last_q <= 1'b0;
      byp_o  <= 1'b0;
      raw_o  <= '0;
    end else if (wrap) begin
      mode_q <= mode_d;
      byp_o  <= bypass_i;
      raw_o  <= bypass_i ? raw_i : '0;
      last_q <= (mode_d == MODE_LOOP) && pat_last;
      unique case (mode_d)
        MODE_USER: begin
          chr_o  <= data_i;
          ctl_o  <= ctrl_i;
          ena_no <= ena_ni;
          enb_no <= enb_ni;
        end
        MODE_IDLE: begin
          chr_o  <= IDLE_CHR[DW-1:0];
          ctl_o  <= 1'b0;
          ena_no <= 1'b0;
          enb_no <= 1'b1;
        end
        default: begin
          chr_o  <= pat_chr;
          ctl_o  <= pat_ctl;
          ena_no <= 1'b0;
          enb_no <= 1'b1;
        end
      endcase
    end
  end

  lst_strobe #(.PHASES(PHASES), .LOW_PHASES(LOW_PHASES)) u_strobe (
    .phase_i(phase_q),
    .mode_i (mode_q),
    .ena_ni (ena_no),
    .last_i (last_q),
    .rd_no  (rd_no)
  );
endmodule

// File: rtl/lst_tx_seq_chk.sv
module lst_tx_seq_chk
  import lst_pkg::*;
#(
  parameter int PHASES = 10,
  parameter int DW     = 8,
  localparam int PW = $clog2(PHASES)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [PW-1:0] phase_i,
  input logic [1:0]    mode_i,
  input logic [DW-1:0] chr_o,
  input logic          ctl_o,
  input logic          rd_no,
  input logic          ena_no,
  input logic          enb_no,
  input logic          bist_en_ni,
  input logic          ena_ni,
  input logic          enb_ni
);
  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i == PW'(PHASES - 1) |=> phase_i == '0);  // R1

  AST_CHAR_HELD_MIDBYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i != PW'(PHASES - 1) |=> $stable(chr_o) && $stable(ctl_o));  // R1

  AST_STROBE_FALLS_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_no) |-> phase_i == '0);  // R4

  AST_IDLE_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'(MODE_IDLE) |-> chr_o == IDLE_CHR[DW-1:0] && !ctl_o && rd_no);  // R5

  AST_SELFTEST_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i != 2'(MODE_USER) |-> !ena_no && enb_no);  // R6

  AST_MARKER_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'(MODE_LOOP) && !rd_no && phase_i == PW'(PHASES - 1)
     && !bist_en_ni && !(ena_ni && enb_ni))
    |=> chr_o == MARK_CHR[DW-1:0] && ctl_o);  // R8
endmodule

bind lst_tx_seq lst_tx_seq_chk #(.PHASES(PHASES), .DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .phase_i   (phase_q),
  .mode_i    (mode_q),
  .chr_o     (chr_o),
  .ctl_o     (ctl_o),
  .rd_no     (rd_no),
  .ena_no    (ena_no),
  .enb_no    (enb_no),
  .bist_en_ni(bist_en_ni),
  .ena_ni    (ena_ni),
  .enb_ni    (enb_ni)
);

// File: tb/tb_lst_tx_seq.sv
`timescale 1ns/1ps
module tb_lst_tx_seq;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bist_n = 1'b1, ena_n = 1'b1, enb_n = 1'b1, svs = 1'b0, byp = 1'b0, ctrl = 1'b0;
  logic [7:0] data = '0;
  logic [9:0] raw = '0;
  logic [7:0] chr;
  logic       ctl, ena_o, enb_o, byp_o, rd;
  logic [9:0] raw_o;

  always #2.5 clk = ~clk;

  lst_tx_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .bist_en_ni(bist_n), .ena_ni(ena_n), .enb_ni(enb_n),
    .svs_i(svs), .bypass_i(byp), .data_i(data), .ctrl_i(ctrl), .raw_i(raw),
    .chr_o(chr), .ctl_o(ctl), .ena_no(ena_o), .enb_no(enb_o), .byp_o(byp_o),
    .raw_o(raw_o), .rd_no(rd)
  );

  int n_chk = 0, n_fail = 0, ph = 0;
  logic [8:0] m_lfsr = 9'h1FF;
  // expected state of current byte (e_*) and of the byte being loaded (p_*)
  int e_mode = 0, p_mode;
  logic [7:0] e_chr = 0, p_chr;
  logic e_ctl = 0, e_ena = 1, e_enb = 1, e_last = 0, e_byp = 0;
  logic p_ctl, p_ena, p_enb, p_last, p_byp;
  logic [9:0] e_raw = 0, p_raw;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compute_pend();
    logic [8:0] cur;
    cur = (!bist_n && svs) ? 9'h1FF : m_lfsr;
    m_lfsr = {cur[7:0], cur[8] ^ cur[4]};
    p_byp = byp;
    p_raw = byp ? raw : 10'h0;
    p_last = 1'b0;
    if (bist_n) begin
      p_mode = 0; p_chr = data; p_ctl = ctrl; p_ena = ena_n; p_enb = enb_n;
    end else if (ena_n && enb_n) begin
      p_mode = 1; p_chr = 8'h4A; p_ctl = 0; p_ena = 0; p_enb = 1;
    end else begin
      p_mode = 2; p_ena = 0; p_enb = 1;
      p_last = (cur == 9'h0FF);
      if (cur == 9'h1FF) begin p_chr = 8'hBC; p_ctl = 1; end
      else if (cur[8:6] == 3'b000) begin p_chr = 8'h3C; p_ctl = 1; end
      else begin p_chr = cur[7:0]; p_ctl = 0; end
    end
  endtask

  task automatic check_all();
    string t, tr;
    logic exp_rd;
    t  = (e_mode == 0) ? "R3" : (e_mode == 1) ? "R5" : "R6";
    tr = (e_mode == 0) ? "R4" : (e_mode == 1) ? "R5" : "R8";
    exp_rd = (e_mode == 0) ? !(!e_ena && ph < 6) : (e_mode == 2) ? !e_last : 1'b1;
    chk(t, "chr", int'(chr), int'(e_chr));
    chk(t, "ctl", int'(ctl), int'(e_ctl));
    chk(t, "ena", int'(ena_o), int'(e_ena));
    chk(t, "enb", int'(enb_o), int'(e_enb));
    chk(tr, "rd", int'(rd), int'(exp_rd));
    chk("R10", "byp", int'(byp_o), int'(e_byp));
    chk("R10", "raw", int'(raw_o), int'(e_raw));
  endtask

  // one byte period; optional mid-byte change of data_i (R1)
  task automatic run_byte(input bit mid = 0, input logic [7:0] mid_data = 0);
    do begin
      if (mid && ph == 4) data = mid_data;
      if (ph == 9) compute_pend();
      @(posedge clk);
      ph = (ph == 9) ? 0 : ph + 1;
      @(negedge clk);
      if (ph == 0) begin
        e_mode = p_mode; e_chr = p_chr; e_ctl = p_ctl; e_ena = p_ena; e_enb = p_enb;
        e_last = p_last; e_byp = p_byp; e_raw = p_raw;
      end
      check_all();
    end while (ph != 0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    // R2: reset values
    #12;
    chk("R2", "chr", int'(chr), 0);
    chk("R2", "ctl", int'(ctl), 0);
    chk("R2", "ena", int'(ena_o), 1);
    chk("R2", "enb", int'(enb_o), 1);
    chk("R2", "rd", int'(rd), 1);
    chk("R2", "byp", int'(byp_o), 0);
    chk("R2", "raw", int'(raw_o), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3/R4: sweep all user characters with flag and enable combinations
    for (int v = 0; v < 256; v++) begin
      data = 8'(v); ctrl = v[0]; ena_n = v[1]; enb_n = v[2];
      svs = v[3];  // R9: ignored while self-test is off
      run_byte();
    end
    svs = 0;

    // R1: mid-byte change becomes visible only at the next boundary
    data = 8'h11; ena_n = 0;
    run_byte();
    run_byte(1'b1, 8'h22);
    chk("R1", "mid-byte data", int'(chr), 8'h22);

    // R5: idle pattern
    bist_n = 0; ena_n = 1; enb_n = 1;
    repeat (4) run_byte();

    // R9: restart gives marker, R7: loop length 511, R8: strobe on last byte
    ena_n = 0; svs = 1;
    run_byte();
    chk("R9", "restart marker", int'({ctl, chr}), 9'h1BC);
    svs = 0;
    n = 0;
    do begin run_byte(); n++; end while (!(chr == 8'hBC && ctl) && n < 600);
    chk("R7", "loop length", n, 511);
    ena_n = 1; enb_n = 0;
    repeat (5) run_byte();

    // R9: svs in user mode leaves the free-running sequence untouched
    bist_n = 1; svs = 1; data = 8'h5A;
    repeat (3) run_byte();
    svs = 0; bist_n = 0;
    run_byte();
    chk("R9", "no restart from user svs", int'(chr), int'(p_chr));
    repeat (20) run_byte();

    // R10: bypass path
    bist_n = 1; ena_n = 1; enb_n = 1; byp = 1;
    for (int r = 0; r < 1024; r += 13) begin
      raw = 10'(r); data = 8'(r * 3);
      run_byte();
    end
    byp = 0; raw = 10'h3A5;
    run_byte();
    chk("R10", "raw cleared", int'(raw_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule